// File: doc/BRIEF.md
# DAC Word Sequencer with Auto-Increment

This block turns a stream of received bus bytes into writes of 10-bit codes for a bank of eight output channels, and serves reads of that bank. It sits after the bit-level serial receiver. The receiver has already matched the device address. It hands this block one event per received byte, a pulse for each START and STOP condition, and a pulse each time it needs the next byte to send to the bus master.

The first byte of a write transaction is a pointer. Its low bits choose the starting channel, and its top three bits can also request a reset of the whole bank or of one channel to mid-scale. After the pointer, bytes arrive in pairs: the high byte first, then the low byte. The block issues a staging-register write strobe only after the low byte, and then moves on to the next channel. Bit 7 of the high byte is passed on as an "update all outputs now" flag for the latch controller.

Reads use the pointer that a previous write left behind. The master writes the pointer, sends a repeated START and then the read address. For each channel the block then returns the high byte followed by the low byte. The block also decides whether each byte is acknowledged.

Top module: `dac_word_sequencer`

## Requirements
- R1: After reset, every output pulse (ack_vld, rd_vld, stg_we, rst_all, rst_one) is low, the pointer is channel 0 and the next data byte is taken as a high byte.
- R2: One cycle after the first byte following START, ack_vld is high. ack is high when bits 7..3 are all zero, and that byte then selects channel bits 2..0.
- R3: A pointer byte with bits 7..5 = 100 and bits 4..3 = 00 is acknowledged. One cycle later rst_all pulses for one cycle.
- R4: A pointer byte with bits 7..5 = 010 and bits 4..3 = 00 is acknowledged. One cycle later rst_one pulses, with rst_ch equal to bits 2..0.
- R5: Any other pointer byte is not acknowledged. Every later byte is also not acknowledged and not stored until the next START or STOP.
- R6: The high byte produces no strobe. One cycle after the low byte, stg_we pulses with stg_code = {high[1:0], low[7:0]} and stg_upd = high bit 7. High bits 6..2 are ignored.
- R7: After each committed pair the channel increments. Once channel 7 has been written, further bytes get ack low and produce no strobe.
- R8: A START or STOP that arrives between a high byte and its low byte discards the pair. After START, the next byte is again a pointer.
- R9: One cycle after rd_req, rd_vld pulses. rd_data is first {6'b0, code[9:8]} and then code[7:0] of the pointed channel, after which the pointer advances. Reads past channel 7 return 0x00.
- R10: Every high or low byte that is accepted within channel range is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_evt | input | 1 | START or repeated START seen |
| stop_evt | input | 1 | STOP seen |
| byte_valid | input | 1 | A written byte has been received |
| byte_data | input | 8 | Received byte |
| rd_req | input | 1 | Receiver needs the next byte to send |
| stg_q | input | 80 | Staging register contents, channel i at bits [10i+9:10i] |
| ack_vld | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| rd_vld | output | 1 | rd_data is valid |
| rd_data | output | 8 | Byte to send to the master |
| stg_we | output | 1 | Staging register write strobe |
| stg_ch | output | 3 | Channel to write |
| stg_code | output | 10 | Code to write |
| stg_upd | output | 1 | Update-all flag from high byte bit 7 |
| rst_all | output | 1 | Reset all channels to mid-scale |
| rst_one | output | 1 | Reset one channel to mid-scale |
| rst_ch | output | 3 | Channel for rst_one |

## Verification
All 256 pointer values are swept. This separates plain channel selection, the two reset opcodes, the invalid patterns and out-of-range values, and for each invalid pointer it confirms that the data byte that follows is also refused.

Burst writes start from every channel and run past channel 7. High bytes carry filler in bits 6..2 and set bit 7 on some channels. This shows whether codes are assembled correctly, whether only the low byte triggers a strobe, whether the increment is right and whether writes stop at the end of the bank.

Truncated pairs cut off by STOP or by a repeated START check that nothing is committed and that the pointer is re-armed. Read bursts from every start channel, over a distinct code per channel, check the byte order, the zeroed upper bits and the return value past the end of the bank.

// File: rtl/seq_pkg.sv
// Shared types for the DAC word sequencer.
// Assumes: a pointer byte's top three bits carry the opcode.
package seq_pkg;

    // Transaction phase of the sequencer.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,   // between STOP and START
        SQ_PTR  = 2'd1,   // next written byte is a pointer
        SQ_DATA = 2'd2,   // high/low pairs being received
        SQ_HOLD = 2'd3    // refusing bytes until START or STOP
    } sq_mode_t;

    // Classification of a pointer byte.
    typedef enum logic [1:0] {
        PK_BAD     = 2'd0,
        PK_CHAN    = 2'd1,
        PK_RST_ALL = 2'd2,
        PK_RST_ONE = 2'd3
    } ptr_kind_t;

    localparam logic [2:0] OP_CHAN    = 3'b000;
    localparam logic [2:0] OP_RST_ALL = 3'b100;
    localparam logic [2:0] OP_RST_ONE = 3'b010;

endpackage

// File: rtl/seq_ptr_decode.sv
// Pointer byte classifier.
// Takes a pointer byte and reports its kind and channel.
// Assumes: NCH <= 32. Channel bits sit at the bottom of the low five bits
// and every low bit above them must be zero.
module seq_ptr_decode
    import seq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [7:0]    ptr_byte,
    output ptr_kind_t     kind,
    output logic [PW-1:0] ch
);

    logic in_range;

    // Channel field must name an existing channel, with spare low bits at zero.
    always_comb begin
        in_range = ({27'd0, ptr_byte[4:0]} < NCH);
        ch       = ptr_byte[PW-1:0];
    end

    // Opcode decode of the top three bits.
    always_comb begin
        kind = PK_BAD;
        if (in_range) begin
            case (ptr_byte[7:5])
                OP_CHAN:    kind = PK_CHAN;
                OP_RST_ALL: kind = PK_RST_ALL;
                OP_RST_ONE: kind = PK_RST_ONE;
                default:    kind = PK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/seq_read_mux.sv
// Read byte selector.
// Picks the high or low byte of the pointed channel's staging code.
// Assumes: 9 <= CW <= 16. The high byte carries code bits above 7 with all
// other bits zero. A pointer past the bank returns zero.
module seq_read_mux #(
    parameter int NCH = 8,
    parameter int CW  = 10,
    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int HW = CW - 8
) (
    input  logic [NCH*CW-1:0] stg_q,
    input  logic [PW-1:0]     ch,
    input  logic              past_end,
    input  logic              low_sel,
    output logic [7:0]        rd_byte
);

    logic [CW-1:0] codes [NCH];

    // Unpack the flat staging bus into one code per channel.
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_unpack
            assign codes[g] = stg_q[g*CW +: CW];
        end
    endgenerate

    logic [CW-1:0] sel_code;

    // Choose the byte to return.
    always_comb begin
        sel_code = codes[ch];
        if (past_end)
            rd_byte = 8'h00;
        else if (low_sel)
            rd_byte = sel_code[7:0];
        else
            rd_byte = {{(8-HW){1'b0}}, sel_code[CW-1:8]};
    end

endmodule

// File: rtl/dac_word_sequencer.sv
// DAC word sequencer.
// Reads the pointer byte, builds high/low pairs into channel codes,
// strobes staging writes, auto-increments the pointer, serves reads and
// decides the acknowledge bit for each byte.
// Assumes: start_evt, stop_evt, byte_valid and rd_req are single-cycle pulses.
// START or STOP wins if it arrives in the same cycle as a byte.
module dac_word_sequencer
    import seq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 10,
    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int HW = CW - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              rd_req,
    input  logic [NCH*CW-1:0] stg_q,
    output logic              ack_vld,
    output logic              ack,
    output logic              rd_vld,
    output logic [7:0]        rd_data,
    output logic              stg_we,
    output logic [PW-1:0]     stg_ch,
    output logic [CW-1:0]     stg_code,
    output logic              stg_upd,
    output logic              rst_all,
    output logic              rst_one,
    output logic [PW-1:0]     rst_ch
);

    localparam logic [PW-1:0] LAST_CH = PW'(NCH - 1);

    sq_mode_t      mode_q;
    logic [PW-1:0] ptr_q;
    logic          past_end_q;
    logic          low_q;       // 1: next byte is the low byte
    logic [HW-1:0] hold_code_q;
    logic          hold_upd_q;

    ptr_kind_t     pk;
    logic [PW-1:0] pk_ch;
    logic [7:0]    rd_byte;

    seq_ptr_decode #(.NCH(NCH)) u_dec (
        .ptr_byte (byte_data),
        .kind     (pk),
        .ch       (pk_ch)
    );

    seq_read_mux #(.NCH(NCH), .CW(CW)) u_rmux (
        .stg_q    (stg_q),
        .ch       (ptr_q),
        .past_end (past_end_q),
        .low_sel  (low_q),
        .rd_byte  (rd_byte)
    );

    // Main sequencer: transaction phase, pointer, pair assembly and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= SQ_IDLE;
            ptr_q       <= '0;
            past_end_q  <= 1'b0;
            low_q       <= 1'b0;
            hold_code_q <= '0;
            hold_upd_q  <= 1'b0;
            ack_vld     <= 1'b0;
            ack         <= 1'b0;
            rd_vld      <= 1'b0;
            rd_data     <= 8'h00;
            stg_we      <= 1'b0;
            stg_ch      <= '0;
            stg_code    <= '0;
            stg_upd     <= 1'b0;
            rst_all     <= 1'b0;
            rst_one     <= 1'b0;
            rst_ch      <= '0;
        end else begin
            ack_vld <= 1'b0;
            rd_vld  <= 1'b0;
            stg_we  <= 1'b0;
            rst_all <= 1'b0;
            rst_one <= 1'b0;
            if (start_evt) begin
                mode_q <= SQ_PTR;
                low_q  <= 1'b0;
            end else if (stop_evt) begin
                mode_q <= SQ_IDLE;
                low_q  <= 1'b0;
            end else if (byte_valid) begin
                ack_vld <= 1'b1;
                ack     <= 1'b0;
                case (mode_q)
                    SQ_PTR: begin
                        if (pk == PK_BAD) begin
                            mode_q <= SQ_HOLD;
                        end else begin
                            ack        <= 1'b1;
                            mode_q     <= SQ_DATA;
                            ptr_q      <= pk_ch;
                            past_end_q <= 1'b0;
                            low_q      <= 1'b0;
                            rst_all    <= (pk == PK_RST_ALL);
                            rst_one    <= (pk == PK_RST_ONE);
                            rst_ch     <= pk_ch;
                        end
                    end
                    SQ_DATA: begin
                        if (!past_end_q) begin
                            ack <= 1'b1;
                            if (!low_q) begin
                                hold_code_q <= byte_data[HW-1:0];
                                hold_upd_q  <= byte_data[7];
                                low_q       <= 1'b1;
                            end else begin
                                stg_we   <= 1'b1;
                                stg_ch   <= ptr_q;
                                stg_code <= {hold_code_q, byte_data};
                                stg_upd  <= hold_upd_q;
                                low_q    <= 1'b0;
                                if (ptr_q == LAST_CH)
                                    past_end_q <= 1'b1;
                                else
                                    ptr_q <= ptr_q + 1'b1;
                            end
                        end
                    end
                    default: ack <= 1'b0;
                endcase
            end else if (rd_req) begin
                rd_vld  <= 1'b1;
                rd_data <= rd_byte;
                if (!low_q) begin
                    low_q <= 1'b1;
                end else begin
                    low_q <= 1'b0;
                    if (ptr_q == LAST_CH)
                        past_end_q <= 1'b1;
                    else
                        ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    // Acknowledge decisions only answer a received byte.
    assert_ack_follows_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_valid));

    // A staging write is always an acknowledged low byte.
    assert_commit_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stg_we |-> (ack_vld && ack));

    // A commit only happens when a high byte was already held.
    assert_commit_after_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stg_we |-> $past(low_q));

    // The two reset requests never fire together.
    assert_reset_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_all && rst_one));

    // Reset requests only come from a pointer byte.
    assert_reset_from_pointer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_all || rst_one) |-> $past(mode_q == SQ_PTR));

    // Bytes that arrive while refusing are never acknowledged.
    assert_hold_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && $past(mode_q == SQ_HOLD)) |-> !ack);

    // Read data only answers a request.
    assert_read_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(rd_req));

    // The high read byte carries only code bits above bit 7.
    assert_high_byte_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !$past(low_q)) |-> ((rd_data >> HW) == 8'h00));

    // No strobe once the end of the bank has been reached.
    assert_no_write_past_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !start_evt && !stop_evt && past_end_q && mode_q == SQ_DATA) |=> !stg_we);

endmodule

// File: tb/dac_word_sequencer_tb.sv
// Self-checking bench: pointer sweep, burst writes, truncated pairs, burst reads.
module dac_word_sequencer_tb;

    localparam int NCH = 8;
    localparam int CW  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_evt = 1'b0, stop_evt = 1'b0, byte_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [NCH*CW-1:0] stg_q;
    logic ack_vld, ack, rd_vld, stg_we, stg_upd, rst_all, rst_one;
    logic [7:0] rd_data;
    logic [2:0] stg_ch, rst_ch;
    logic [CW-1:0] stg_code;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dac_word_sequencer #(.NCH(NCH), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_valid(byte_valid), .byte_data(byte_data), .rd_req(rd_req),
        .stg_q(stg_q), .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld),
        .rd_data(rd_data), .stg_we(stg_we), .stg_ch(stg_ch), .stg_code(stg_code),
        .stg_upd(stg_upd), .rst_all(rst_all), .rst_one(rst_one), .rst_ch(rst_ch)
    );

    // Bench-owned staging contents: a distinct code per channel.
    function automatic logic [CW-1:0] bank_code(int i);
        return CW'((i * 133 + 77) % 1024);
    endfunction

    initial begin
        for (int i = 0; i < NCH; i++) stg_q[i*CW +: CW] = bank_code(i);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    // Send one byte; outputs are sampled on the following negedge.
    task automatic put(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic get();
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ack_vld && !rd_vld && !stg_we && !rst_all && !rst_one, "R1 pulses low",
            {ack_vld, rd_vld, stg_we, rst_all, rst_one}, 0);
        rst_n = 1'b1;
        // R1: pointer 0 and high phase after reset: read gives high byte of channel 0
        get();
        chk(rd_vld && rd_data == {6'b0, bank_code(0)[9:8]}, "R1 ptr0 high", rd_data,
            {6'b0, bank_code(0)[9:8]});
        ev_stop();

        // R2..R5: sweep every pointer value
        for (int p = 0; p < 256; p++) begin
            bit ok_ptr;
            int kind;
            ok_ptr = ((p & 31) < NCH) && ((p >> 5) == 0 || (p >> 5) == 4 || (p >> 5) == 2);
            kind = ok_ptr ? (p >> 5) : -1;
            ev_start();
            put(8'(p));
            chk(ack_vld && ack == ok_ptr, "R2 pointer ack", {ack_vld, ack}, {1'b1, ok_ptr});
            chk(rst_all == (kind == 4), "R3 reset all pulse", rst_all, kind == 4);
            chk(rst_one == (kind == 2) && (kind != 2 || rst_ch == 3'(p & 7)),
                "R4 reset one pulse", {rst_one, rst_ch}, {(kind == 2), 3'(p & 7)});
            if (!ok_ptr) begin
                put(8'h00);
                chk(ack_vld && !ack, "R5 data refused", ack, 0);
                put(8'h11);
                chk(!ack && !stg_we, "R5 nothing stored", {ack, stg_we}, 0);
            end
            ev_stop();
        end

        // R6, R7, R10: burst writes from every start channel past the end
        for (int s = 0; s < NCH; s++) begin
            ev_start();
            put(8'(s));
            for (int c = s; c < NCH; c++) begin
                int code;
                bit upd;
                code = (c * 97 + s * 31 + 5) % 1024;
                upd = ((c + s) % 3 == 0);
                put({upd, 5'b10110 ^ 5'(c), 2'(code >> 8)});
                chk(ack && !stg_we, "R6 high byte no strobe", {ack, stg_we}, 2'b10);
                put(8'(code & 255));
                chk(ack && stg_we && stg_ch == 3'(c) && stg_code == CW'(code) && stg_upd == upd,
                    "R6 commit", {stg_we, stg_upd, stg_ch, stg_code},
                    {1'b1, upd, 3'(c), CW'(code)});
            end
            put(8'h03);
            chk(ack_vld && !ack && !stg_we, "R7 past end", {ack, stg_we}, 0);
            put(8'h44);
            chk(!ack && !stg_we, "R7 past end low", {ack, stg_we}, 0);
            ev_stop();
        end

        // R8: pair cut by STOP, then by repeated START
        ev_start(); put(8'h04); put(8'h02);
        ev_stop();
        chk(!stg_we, "R8 stop no strobe", stg_we, 0);
        ev_start(); put(8'h04);
        chk(ack && !stg_we, "R8 pointer after stop", {ack, stg_we}, 2'b10);
        put(8'h02); put(8'h34);
        chk(stg_we && stg_ch == 3'd4 && stg_code == 10'h234, "R8 fresh pair after stop",
            {stg_ch, stg_code}, {3'd4, 10'h234});
        put(8'h01);
        ev_start();
        put(8'h05);
        chk(ack && !stg_we, "R8 byte after start is pointer", {ack, stg_we}, 2'b10);
        put(8'h03); put(8'hA5);
        chk(stg_we && stg_ch == 3'd5 && stg_code == 10'h3A5, "R8 commit after restart",
            {stg_ch, stg_code}, {3'd5, 10'h3A5});
        ev_stop();

        // R9: burst reads from every start channel past the end
        for (int s = 0; s < NCH; s++) begin
            ev_start(); put(8'(s)); ev_start();
            for (int c = s; c < NCH; c++) begin
                get();
                chk(rd_vld && rd_data == {6'b0, bank_code(c)[9:8]}, "R9 read high",
                    rd_data, {6'b0, bank_code(c)[9:8]});
                get();
                chk(rd_vld && rd_data == bank_code(c)[7:0], "R9 read low",
                    rd_data, bank_code(c)[7:0]);
            end
            get();
            chk(rd_vld && rd_data == 8'h00, "R9 read past end", rd_data, 0);
            ev_stop();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule